// File: doc/BRIEF.md
# GPIO Special-Function Output Multiplexer

This block sits between a register file and seven bidirectional pads. For each pin it applies a direction bit and an output data bit. It returns a readback word that shows the driven value for output pins and the synchronized pad level for input pins. Several pins can carry a special function instead of plain register data:
- Two pins mirror a two-bit external multiplexer selection field.
- One pin shows a calibration-busy status.
- One pin shows a fault interrupt built from two error words.
- One pin carries either of two internal clocks out, or brings an external clock in.

A special function on an output pin takes effect only when that pin's direction bit selects output. On the clock pin the input path works the other way round. When that pin is an input and its clock-in enable is set, the synchronized level feeds an edge divider. The divider emits a single-cycle tick after every (divide value + 1) edges of the chosen polarity.

The register file and clock generation are outside the block. All control arrives as register-level inputs, and the block drives the pad output-enable and output-value lines.

Top module: `gpio_sf_mux`

## Requirements
- R1: While `rst` is high, `pad_oe` is all zeros and `ext_clk_tick` is 0, so every pin starts as an input.
- R2: Outside reset, `pad_oe[i]` equals `pin_dir[i]`. A pin that is not driven presents 0 on `pad_out[i]`.
- R3: An output pin without an active special function drives `pin_wdata[i]`.
- R4: When pin 0 is an output and `xmux_en[0]` is 1, it drives `mux_field[0]`. When pin 1 is an output and `xmux_en[1]` is 1, it drives `mux_field[1]`.
- R5: When pin 2 is an output and `busy_out_en` is 1, it drives `cal_busy`.
- R6: When pin 3 is an output and `fault_out_en` is 1, it drives the OR of all bits of `analog_err` and `digital_err`.
- R7: When pin 4 is an output and `clk_out_en` is 1, it drives `osc_1m` if `clk_out_sel` is 0 and `osc_125k` if `clk_out_sel` is 1.
- R8: A special-function enable on an input pin has no effect. The pin stays undriven, and its readback shows the pad level.
- R9: For an output pin, `rd_data[i]` equals the value actually driven, including any special function.
- R10: For an input pin, `rd_data[i]` shows the level `pad_in[i]` had two clock edges earlier, after a two-flop synchronizer.
- R11: When pin 4 is an input and `clk_in_en` is 1, `ext_clk_tick` pulses for one cycle on every (`sync_div`+1)-th synchronized edge of pin 4. With `sync_pol` at 0 the divider counts rising edges; with `sync_pol` at 1 it counts falling edges. Otherwise no tick occurs and the edge count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_dir | input | 7 | Direction per pin, 1 = output |
| pin_wdata | input | 7 | Register output data per pin |
| mux_field | input | 2 | External multiplexer selection field |
| xmux_en | input | 2 | Mirror enables for pins 0 and 1 |
| busy_out_en | input | 1 | Calibration-busy function on pin 2 |
| fault_out_en | input | 1 | Fault-interrupt function on pin 3 |
| clk_out_en | input | 1 | Clock output function on pin 4 |
| clk_in_en | input | 1 | Clock input function on pin 4 |
| clk_out_sel | input | 1 | 0 = 1 MHz clock out, 1 = 125 kHz clock out |
| sync_pol | input | 1 | 0 = count rising edges, 1 = count falling edges |
| sync_div | input | 3 | Input clock divide value minus one |
| cal_busy | input | 1 | Calibration-busy status |
| analog_err | input | 8 | Analog error word |
| digital_err | input | 8 | Digital error word |
| osc_1m | input | 1 | 1 MHz master clock level |
| osc_125k | input | 1 | 125 kHz clock level |
| pad_in | input | 7 | Pad input levels |
| pad_out | output | 7 | Pad output values |
| pad_oe | output | 7 | Pad output enables |
| rd_data | output | 7 | Readback word |
| ext_clk_tick | output | 1 | Divided external clock tick |

## Verification
Several relations are checked on every clock outside reset:
- the forced-input state during reset;
- the calibration-busy and fault-interrupt pins whenever their functions are live;
- readback of output pins against the pad values;
- the two-edge synchronizer delay on input pin 0;
- the rule that a tick only follows a cycle in which clock input was enabled on an input pin.

Only the bench scenarios show the other behaviours:
- the mirrored multiplexer bits and the clock-select choice;
- the absence of any effect from enables on input pins;
- the tick counts for each divide value and each edge polarity.

// File: rtl/gpio_sf_pkg.sv
package gpio_sf_pkg;

    localparam int PIN_XMUX0 = 0;
    localparam int PIN_XMUX1 = 1;
    localparam int PIN_BUSY  = 2;
    localparam int PIN_FAULT = 3;
    localparam int PIN_CLK   = 4;
    localparam int MIN_PINS  = 5;

    typedef struct packed {
        logic [1:0] xmux_en;
        logic       busy_en;
        logic       fault_en;
        logic       clk_out_en;
        logic       clk_sel;
    } sf_out_cfg_t;

    typedef struct packed {
        logic [1:0] mux_field;
        logic       cal_busy;
        logic       fault_any;
        logic       osc_1m;
        logic       osc_125k;
    } sf_src_t;

    function automatic logic edge_hit(input logic prev, input logic cur, input logic fall);
        return fall ? (prev & ~cur) : (~prev & cur);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux
    import gpio_sf_pkg::*;
#(
    parameter int NUM_PINS = 7
) (
    input  logic                rst,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] wdata,
    input  sf_out_cfg_t         cfg,
    input  sf_src_t             src,
    output logic [NUM_PINS-1:0] drive,
    output logic [NUM_PINS-1:0] oe,
    output logic [NUM_PINS-1:0] out
);
    logic [NUM_PINS-1:0] sf_on;
    logic [NUM_PINS-1:0] sf_val;

    always_comb begin
        sf_on  = '0;
        sf_val = '0;
        sf_on[PIN_XMUX0]  = cfg.xmux_en[0];
        sf_val[PIN_XMUX0] = src.mux_field[0];
        sf_on[PIN_XMUX1]  = cfg.xmux_en[1];
        sf_val[PIN_XMUX1] = src.mux_field[1];
        sf_on[PIN_BUSY]   = cfg.busy_en;
        sf_val[PIN_BUSY]  = src.cal_busy;
        sf_on[PIN_FAULT]  = cfg.fault_en;
        sf_val[PIN_FAULT] = src.fault_any;
        sf_on[PIN_CLK]    = cfg.clk_out_en;
        sf_val[PIN_CLK]   = cfg.clk_sel ? src.osc_125k : src.osc_1m;
    end

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_pin
            assign drive[i] = sf_on[i] ? sf_val[i] : wdata[i];
            assign oe[i]    = ~rst & dir[i];
            assign out[i]   = oe[i] & drive[i];
        end
    endgenerate
endmodule

// File: rtl/gpio_clk_in_div.sv
module gpio_clk_in_div
    import gpio_sf_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             level,
    input  logic             fall,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic             prev_q;
    logic [DIV_W-1:0] cnt_q;
    logic             hit;

    assign hit = edge_hit(prev_q, level, fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
            tick   <= 1'b0;
        end else begin
            prev_q <= level;
            if (!enable) begin
                cnt_q <= '0;
                tick  <= 1'b0;
            end else if (hit) begin
                if (cnt_q == div) begin
                    cnt_q <= '0;
                    tick  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    tick  <= 1'b0;
                end
            end else begin
                tick <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/gpio_sf_mux.sv
module gpio_sf_mux
    import gpio_sf_pkg::*;
#(
    parameter int NUM_PINS    = 7,
    parameter int ERR_W       = 8,
    parameter int DIV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_dir,
    input  logic [NUM_PINS-1:0] pin_wdata,
    input  logic [1:0]          mux_field,
    input  logic [1:0]          xmux_en,
    input  logic                busy_out_en,
    input  logic                fault_out_en,
    input  logic                clk_out_en,
    input  logic                clk_in_en,
    input  logic                clk_out_sel,
    input  logic                sync_pol,
    input  logic [DIV_W-1:0]    sync_div,
    input  logic                cal_busy,
    input  logic [ERR_W-1:0]    analog_err,
    input  logic [ERR_W-1:0]    digital_err,
    input  logic                osc_1m,
    input  logic                osc_125k,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] rd_data,
    output logic                ext_clk_tick
);
    sf_out_cfg_t         cfg;
    sf_src_t             src;
    logic [NUM_PINS-1:0] in_sync;
    logic [NUM_PINS-1:0] drive;
    logic                clk_in_live;

    assign cfg = '{xmux_en: xmux_en, busy_en: busy_out_en, fault_en: fault_out_en,
                   clk_out_en: clk_out_en, clk_sel: clk_out_sel};
    assign src = '{mux_field: mux_field, cal_busy: cal_busy,
                   fault_any: (|analog_err) | (|digital_err),
                   osc_1m: osc_1m, osc_125k: osc_125k};

    gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pad_in),
        .dout(in_sync)
    );

    gpio_out_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .rst  (rst),
        .dir  (pin_dir),
        .wdata(pin_wdata),
        .cfg  (cfg),
        .src  (src),
        .drive(drive),
        .oe   (pad_oe),
        .out  (pad_out)
    );

    assign clk_in_live = clk_in_en & ~pin_dir[PIN_CLK];

    gpio_clk_in_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .enable(clk_in_live),
        .level (in_sync[PIN_CLK]),
        .fall  (sync_pol),
        .div   (sync_div),
        .tick  (ext_clk_tick)
    );

    assign rd_data = (pin_dir & drive) | (~pin_dir & in_sync);
endmodule

// File: rtl/gpio_sf_mux_chk.sv
module gpio_sf_mux_chk #(
    parameter int NUM_PINS = 7,
    parameter int ERR_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] pin_dir,
    input logic                busy_out_en,
    input logic                fault_out_en,
    input logic                clk_in_en,
    input logic                cal_busy,
    input logic [ERR_W-1:0]    analog_err,
    input logic [ERR_W-1:0]    digital_err,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] rd_data,
    input logic                ext_clk_tick
);
    logic [1:0] cyc_q;
    always_ff @(posedge clk) begin
        if (rst)              cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    assert_reset_inputs_R1: assert property (@(posedge clk)
        rst |-> (pad_oe == '0 && !ext_clk_tick));

    assert_busy_pin_R5: assert property (@(posedge clk) disable iff (rst)
        (pin_dir[2] && busy_out_en) |-> (pad_out[2] == cal_busy));

    assert_fault_pin_R6: assert property (@(posedge clk) disable iff (rst)
        (pin_dir[3] && fault_out_en) |-> (pad_out[3] == ((|analog_err) | (|digital_err))));

    assert_out_readback_R9: assert property (@(posedge clk) disable iff (rst)
        ((rd_data ^ pad_out) & pin_dir) == '0);

    assert_in_latency_R10: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 2'd2 && !pin_dir[0]) |-> (rd_data[0] == $past(pad_in[0], 2)));

    assert_tick_gate_R11: assert property (@(posedge clk) disable iff (rst)
        ext_clk_tick |-> $past(clk_in_en && !pin_dir[4]));
endmodule

bind gpio_sf_mux gpio_sf_mux_chk #(.NUM_PINS(NUM_PINS), .ERR_W(ERR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pin_dir     (pin_dir),
    .busy_out_en (busy_out_en),
    .fault_out_en(fault_out_en),
    .clk_in_en   (clk_in_en),
    .cal_busy    (cal_busy),
    .analog_err  (analog_err),
    .digital_err (digital_err),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .rd_data     (rd_data),
    .ext_clk_tick(ext_clk_tick)
);

// File: tb/gpio_sf_mux_bench.sv
module gpio_sf_mux_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] pin_dir = '0, pin_wdata = '0, pad_in = '0;
    logic [1:0] mux_field = '0, xmux_en = '0;
    logic       busy_out_en = 0, fault_out_en = 0, clk_out_en = 0, clk_in_en = 0;
    logic       clk_out_sel = 0, sync_pol = 0, cal_busy = 0, osc_1m = 0, osc_125k = 0;
    logic [2:0] sync_div = '0;
    logic [7:0] analog_err = '0, digital_err = '0;
    logic [6:0] pad_out, pad_oe, rd_data;
    logic       ext_clk_tick;

    int checks = 0;
    int errors = 0;
    int ticks  = 0;
    bit count_ticks = 0;
    bit done = 0;

    typedef struct {
        logic [6:0] oe;
        logic [6:0] out;
        logic [6:0] rd;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    gpio_sf_mux u_gpio_sf_mux (
        .clk(clk), .rst(rst), .pin_dir(pin_dir), .pin_wdata(pin_wdata),
        .mux_field(mux_field), .xmux_en(xmux_en), .busy_out_en(busy_out_en),
        .fault_out_en(fault_out_en), .clk_out_en(clk_out_en), .clk_in_en(clk_in_en),
        .clk_out_sel(clk_out_sel), .sync_pol(sync_pol), .sync_div(sync_div),
        .cal_busy(cal_busy), .analog_err(analog_err), .digital_err(digital_err),
        .osc_1m(osc_1m), .osc_125k(osc_125k), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .rd_data(rd_data), .ext_clk_tick(ext_clk_tick)
    );

    task automatic check1(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        if (count_ticks && ext_clk_tick) ticks++;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check1({e.req, " oe"}, 32'(pad_oe), 32'(e.oe));
            check1({e.req, " out"}, 32'(pad_out), 32'(e.out));
            check1({e.req, " rd"}, 32'(rd_data), 32'(e.rd));
        end
    end

    // driver: settle three edges, then push the expectation
    task automatic expect_item(input logic [6:0] oe, input logic [6:0] out,
                               input logic [6:0] rd, input string req);
        exp_t e;
        repeat (3) @(posedge clk);
        e.oe = oe; e.out = out; e.rd = rd; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic toggle_pin4(input int n);
        for (int k = 0; k < n; k++) begin
            pad_in[4] = 1'b1;
            repeat (4) @(negedge clk);
            pad_in[4] = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        pin_dir = 7'h7F;
        repeat (3) @(negedge clk);
        // R1: reset keeps all pins undriven
        check1("R1 oe in reset", 32'(pad_oe), 0);
        check1("R1 tick in reset", 32'(ext_clk_tick), 0);
        pin_dir = '0;
        @(negedge clk); rst = 1'b0; #1;

        // R10 / R2: all inputs, readback of pad levels
        pad_in = 7'h55;
        expect_item(7'h00, 7'h00, 7'h55, "R10 inputs");

        // R3 / R2: plain outputs
        pin_dir = 7'h7F; pin_wdata = 7'h2A;
        expect_item(7'h7F, 7'h2A, 7'h2A, "R3 plain out");

        // R4: external mux mirror on pins 0 and 1
        pin_wdata = 7'h01; xmux_en = 2'b11; mux_field = 2'b10;
        expect_item(7'h7F, 7'h02, 7'h02, "R4 mux 10");
        mux_field = 2'b01;
        expect_item(7'h7F, 7'h01, 7'h01, "R4 mux 01");
        xmux_en = 2'b00; pin_wdata = 7'h00;

        // R5: calibration busy on pin 2
        busy_out_en = 1; cal_busy = 1;
        expect_item(7'h7F, 7'h04, 7'h04, "R5 busy high");
        cal_busy = 0; pin_wdata = 7'h04;
        expect_item(7'h7F, 7'h00, 7'h00, "R5 busy low");
        busy_out_en = 0; pin_wdata = 7'h00;

        // R6: fault interrupt on pin 3
        fault_out_en = 1; digital_err = 8'h10;
        expect_item(7'h7F, 7'h08, 7'h08, "R6 fault digital");
        digital_err = 8'h00; analog_err = 8'h80;
        expect_item(7'h7F, 7'h08, 7'h08, "R6 fault analog");
        analog_err = 8'h00; pin_wdata = 7'h08;
        expect_item(7'h7F, 7'h00, 7'h00, "R6 no fault");
        fault_out_en = 0; pin_wdata = 7'h00;

        // R7: clock out select on pin 4
        clk_out_en = 1; osc_1m = 1; osc_125k = 0; clk_out_sel = 0;
        expect_item(7'h7F, 7'h10, 7'h10, "R7 sel 1m");
        clk_out_sel = 1;
        expect_item(7'h7F, 7'h00, 7'h00, "R7 sel 125k");
        clk_out_en = 0; osc_1m = 0;

        // R8 / R9: enables on input pins change nothing
        pin_dir = 7'h60; pin_wdata = 7'h60; pad_in = 7'h0A;
        xmux_en = 2'b11; mux_field = 2'b11; busy_out_en = 1; cal_busy = 1;
        fault_out_en = 1; analog_err = 8'h01; clk_out_en = 1; osc_1m = 1; clk_out_sel = 0;
        expect_item(7'h60, 7'h60, 7'h6A, "R8 sf on inputs");
        xmux_en = 0; busy_out_en = 0; fault_out_en = 0; clk_out_en = 0;
        analog_err = 0; cal_busy = 0; osc_1m = 0; mux_field = 0;

        // R10: two-edge latency on pin 0
        pin_dir = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        pad_in[0] = 1'b1;
        @(negedge clk);
        check1("R10 after one edge", 32'(rd_data[0]), 0);
        @(negedge clk);
        check1("R10 after two edges", 32'(rd_data[0]), 1);
        pad_in = '0;
        repeat (3) @(negedge clk);

        // R11: rising edges, divide by 3
        sync_div = 3'd2; sync_pol = 0; clk_in_en = 1;
        ticks = 0; count_ticks = 1;
        toggle_pin4(9);
        repeat (4) @(negedge clk);
        check1("R11 rising div3 ticks", 32'(ticks), 3);
        clk_in_en = 0; repeat (3) @(negedge clk);

        // R11: falling edges, divide by 2
        sync_div = 3'd1; sync_pol = 1; clk_in_en = 1; ticks = 0;
        toggle_pin4(6);
        repeat (4) @(negedge clk);
        check1("R11 falling div2 ticks", 32'(ticks), 3);

        // R11: pin 4 as output blocks clock input
        pin_dir = 7'h10; sync_div = 3'd0; ticks = 0;
        toggle_pin4(4);
        repeat (4) @(negedge clk);
        check1("R11 output pin no ticks", 32'(ticks), 0);
        pin_dir = '0; clk_in_en = 0; ticks = 0;
        toggle_pin4(3);
        repeat (4) @(negedge clk);
        check1("R11 disabled no ticks", 32'(ticks), 0);
        count_ticks = 0;

        // R1: reset again forces inputs
        pin_dir = 7'h7F; rst = 1;
        @(negedge clk);
        check1("R1 oe in second reset", 32'(pad_oe), 0);
        rst = 0;

        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule